// File: doc/BRIEF.md
# Receive-Path Error Event Counter Bank

This block keeps eight error tallies for a T3/E3 receive path. Upstream detectors raise one-cycle strobes for bipolar violations, code violations, loss-of-frame events, framing bit errors, excessive-zero runs, T3 parity errors, T3 C-bit parity errors and far-end block errors. Each strobe advances its own live counter. The host never reads a live counter. It reads a matching holding register, which only changes on an update.

On an update, every live count moves into its holding register and the live counter restarts, all in a single clock. The update comes from exactly one source, chosen by a two-bit mode input:
- an internal one-second timebase, which divides a reference tick enable;
- a software command strobe;
- an external pulse pin, which is synchronized and edge-detected.

One cycle after each update, a done flag marks that fresh holding values are present.

Top module: `pm_counter_bank`

## Requirements
- R1: While rst_n is low, every holding output and upd_done_o read zero, and every live count is cleared.
- R2: Each event strobe bit advances its own counter by exactly one per cycle in which it is high. Bit 0 is bipolar violation, bit 1 code violation, bit 2 loss of frame, bit 3 framing error, bit 4 excessive zeros, bit 5 T3 parity, bit 6 C-bit parity and bit 7 far-end block error. Holding registers do not change between updates.
- R3: A counter that reaches its maximum stays there and does not wrap. The maximum is 65535 for the 16-bit counters and 255 for the 8-bit loss-of-frame counter.
- R4: mode_i selects the update source: 2'b00 none, 2'b01 one-second timer, 2'b10 software, 2'b11 external pin. Sources that are not selected have no effect.
- R5: At the clock edge that performs an update, each holding register takes its live count and the live counter restarts. An event strobed in that same cycle counts as 1 in the new interval.
- R6: The timebase counts cycles with tick_en_i high. From reset it gives one update on every TICKS_PER_SEC-th such cycle, at the edge that samples that tick, and it runs whatever the mode.
- R7: In software mode, a cycle with sw_upd_i high causes an update at that clock edge.
- R8: In external mode, ext_upd_i passes through two synchronizer flops and a rising-edge detector. A high level of any length gives exactly one update, at the third rising clock edge that samples it high.
- R9: upd_done_o is high for exactly the one cycle that follows each update edge, when the new holding values are already visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en_i | input | 1 | Reference tick enable for the one-second timebase |
| evt_i | input | 8 | One-cycle error event strobes, bit mapping as in R2 |
| mode_i | input | 2 | Update source select |
| sw_upd_i | input | 1 | Software update command strobe |
| ext_upd_i | input | 1 | Asynchronous external update pulse |
| hold_bpv_o | output | VIOL_W | Held bipolar violation count |
| hold_cv_o | output | VIOL_W | Held code violation count |
| hold_lof_o | output | LOF_W | Held loss-of-frame count |
| hold_frm_o | output | VIOL_W | Held framing bit error count |
| hold_exz_o | output | VIOL_W | Held excessive zeros count |
| hold_par_o | output | VIOL_W | Held T3 parity error count |
| hold_cbp_o | output | VIOL_W | Held C-bit parity error count |
| hold_febe_o | output | VIOL_W | Held far-end block error count |
| upd_done_o | output | 1 | One-cycle flag after each update |

## Verification
An update and an event strobe can land in the same clock. The risk there is a lost or doubly counted event at the interval boundary. The bench drives a bipolar violation strobe together with a software command. It expects the earlier interval's total in the holding register and a count of exactly one after the next update. A behavioural model runs beside the design, so every update from the timer, the software command or the pin is judged against the events it collected in every cycle.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int NUM_EVT = 8;

  // Event strobe bit positions.
  localparam int IX_BPV  = 0;
  localparam int IX_CV   = 1;
  localparam int IX_LOF  = 2;
  localparam int IX_FRM  = 3;
  localparam int IX_EXZ  = 4;
  localparam int IX_PAR  = 5;
  localparam int IX_CBP  = 6;
  localparam int IX_FEBE = 7;

  typedef enum logic [1:0] {
    UPD_OFF   = 2'b00,
    UPD_TIMER = 2'b01,
    UPD_SW    = 2'b10,
    UPD_EXT   = 2'b11
  } upd_src_e;
endpackage

// File: rtl/pm_sec_timer.sv
module pm_sec_timer #(
  parameter int TICKS = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en_i,
  output logic sec_o
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign sec_o   = tick_en_i & at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_en_i) begin
      cnt_d = at_last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/pm_edge_sync.sv
module pm_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;
endmodule

// File: rtl/pm_sat_counter.sv
module pm_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt_i,
  input  logic         upd_i,
  output logic [W-1:0] live_o,
  output logic [W-1:0] hold_o
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] live_q, live_d, hold_q, hold_d;

  always_comb begin
    live_d = live_q;
    hold_d = hold_q;
    if (upd_i) begin
      hold_d = live_q;
      live_d = evt_i ? W'(1) : '0;
    end else if (evt_i && (live_q != MAXV)) begin
      live_d = live_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      hold_q <= '0;
    end else begin
      live_q <= live_d;
      hold_q <= hold_d;
    end
  end

  assign live_o = live_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/pm_counter_bank.sv
module pm_counter_bank
  import pm_pkg::*;
#(
  parameter int VIOL_W        = 16,
  parameter int LOF_W         = 8,
  parameter int TICKS_PER_SEC = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en_i,
  input  logic [7:0]        evt_i,
  input  logic [1:0]        mode_i,
  input  logic              sw_upd_i,
  input  logic              ext_upd_i,
  output logic [VIOL_W-1:0] hold_bpv_o,
  output logic [VIOL_W-1:0] hold_cv_o,
  output logic [LOF_W-1:0]  hold_lof_o,
  output logic [VIOL_W-1:0] hold_frm_o,
  output logic [VIOL_W-1:0] hold_exz_o,
  output logic [VIOL_W-1:0] hold_par_o,
  output logic [VIOL_W-1:0] hold_cbp_o,
  output logic [VIOL_W-1:0] hold_febe_o,
  output logic              upd_done_o
);
  logic sec_stb, ext_rise, upd, done_q;

  pm_sec_timer #(.TICKS(TICKS_PER_SEC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en_i (tick_en_i),
    .sec_o     (sec_stb)
  );

  pm_edge_sync u_ext (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (ext_upd_i),
    .rise_o  (ext_rise)
  );

  always_comb begin
    unique case (upd_src_e'(mode_i))
      UPD_TIMER: upd = sec_stb;
      UPD_SW:    upd = sw_upd_i;
      UPD_EXT:   upd = ext_rise;
      default:   upd = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= upd;
    end
  end
  assign upd_done_o = done_q;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_cnt
    localparam int W = (i == IX_LOF) ? LOF_W : VIOL_W;
    logic [W-1:0] live_s, hold_s;

    pm_sat_counter #(.W(W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (evt_i[i]),
      .upd_i  (upd),
      .live_o (live_s),
      .hold_o (hold_s)
    );

    if (i == IX_BPV) begin : g_o
      assign hold_bpv_o = hold_s;
    end else if (i == IX_CV) begin : g_o
      assign hold_cv_o = hold_s;
    end else if (i == IX_LOF) begin : g_o
      assign hold_lof_o = hold_s;
    end else if (i == IX_FRM) begin : g_o
      assign hold_frm_o = hold_s;
    end else if (i == IX_EXZ) begin : g_o
      assign hold_exz_o = hold_s;
    end else if (i == IX_PAR) begin : g_o
      assign hold_par_o = hold_s;
    end else if (i == IX_CBP) begin : g_o
      assign hold_cbp_o = hold_s;
    end else begin : g_o
      assign hold_febe_o = hold_s;
    end
  end
endmodule

// File: rtl/pm_counter_bank_chk.sv
module pm_counter_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         evt_i,
  input logic         upd_i,
  input logic [W-1:0] live_o,
  input logic [W-1:0] hold_o
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  // R5: holding register takes the pre-update live count
  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |=> hold_o == $past(live_o));

  // R5: live count restarts, counting a same-cycle event as one
  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |=> live_o == (W'($past(evt_i))));

  // R3: saturated counter stays at maximum
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (live_o == MAXV && !upd_i) |=> live_o == MAXV);

  // R2: holding register is frozen between updates
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(hold_o));
endmodule

module pm_bank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_i,
  input logic       sw_upd_i,
  input logic       upd,
  input logic       upd_done_o
);
  // R4: no update source when mode is off
  a_r4_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i == 2'b00 |-> !upd);

  // R4: software mode reacts only to the command strobe
  a_r4_sw_only: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b10 && !sw_upd_i) |-> !upd);

  // R9: done follows every update
  a_r9_done: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> upd_done_o);

  // R9: done only after an update
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> !upd_done_o);

  // R8: an external edge never yields back-to-back updates
  a_r8_single: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b11 && upd) |=> !(mode_i == 2'b11 && upd));
endmodule

bind pm_sat_counter pm_counter_chk #(.W(W)) u_cnt_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .upd_i(upd_i),
  .live_o(live_o), .hold_o(hold_o)
);

bind pm_counter_bank pm_bank_chk u_bank_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .sw_upd_i(sw_upd_i),
  .upd(upd), .upd_done_o(upd_done_o)
);

// File: tb/tb_pm_counter_bank.sv
module tb_pm_counter_bank;
  localparam int TPS = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en_i, sw_upd_i, ext_upd_i;
  logic [7:0]  evt_i;
  logic [1:0]  mode_i;
  logic [15:0] h_bpv, h_cv, h_frm, h_exz, h_par, h_cbp, h_febe;
  logic [7:0]  h_lof;
  logic        upd_done_o;

  int checks = 0, failures = 0, pulses = 0;
  bit done_flag = 1'b0;

  // behavioural reference state
  int m_live[8], m_hold[8], m_tcnt;
  bit m_s1, m_s2, m_s3, m_done;

  always #5 clk = ~clk;

  pm_counter_bank #(.VIOL_W(16), .LOF_W(8), .TICKS_PER_SEC(TPS)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en_i), .evt_i(evt_i),
    .mode_i(mode_i), .sw_upd_i(sw_upd_i), .ext_upd_i(ext_upd_i),
    .hold_bpv_o(h_bpv), .hold_cv_o(h_cv), .hold_lof_o(h_lof),
    .hold_frm_o(h_frm), .hold_exz_o(h_exz), .hold_par_o(h_par),
    .hold_cbp_o(h_cbp), .hold_febe_o(h_febe), .upd_done_o(upd_done_o)
  );

  function automatic int hold_of(int i);
    case (i)
      0: return int'(h_bpv);
      1: return int'(h_cv);
      2: return int'(h_lof);
      3: return int'(h_frm);
      4: return int'(h_exz);
      5: return int'(h_par);
      6: return int'(h_cbp);
      default: return int'(h_febe);
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(logic [7:0] m);
    evt_i = m; cyc(1); evt_i = '0;
  endtask

  task automatic sw_pulse();
    sw_upd_i = 1'b1; cyc(1); sw_upd_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // reference model: R2 R3 R4 R5 R6 R7 R8 R9
  initial begin
    for (int i = 0; i < 8; i++) begin m_live[i] = 0; m_hold[i] = 0; end
    m_tcnt = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_done = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin m_live[i] = 0; m_hold[i] = 0; end
      m_tcnt = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_done = 0;
    end else begin
      bit sec, rise, u;
      sec  = tick_en_i && (m_tcnt == TPS - 1);
      rise = m_s2 && !m_s3;
      if (tick_en_i) m_tcnt = (m_tcnt == TPS - 1) ? 0 : m_tcnt + 1;
      case (mode_i)
        2'b01:   u = sec;
        2'b10:   u = sw_upd_i;
        2'b11:   u = rise;
        default: u = 1'b0;
      endcase
      for (int i = 0; i < 8; i++) begin
        int mx;
        mx = (i == 2) ? 255 : 65535;
        if (u) begin
          m_hold[i] = m_live[i];
          m_live[i] = evt_i[i] ? 1 : 0;
        end else if (evt_i[i] && m_live[i] < mx) begin
          m_live[i]++;
        end
      end
      m_done = u;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_upd_i;
    end
  end

  // cycle compare against model, and pulse counting
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      for (int i = 0; i < 8; i++)
        if (hold_of(i) != m_hold[i]) chk(1'b0, "R5 model hold", hold_of(i), m_hold[i]);
      chk(upd_done_o == m_done, "R9 model done", int'(upd_done_o), int'(m_done));
      if (upd_done_o) pulses++;
    end
  end

  initial begin
    #1_500_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tick_en_i = 0; sw_upd_i = 0; ext_upd_i = 0;
    evt_i = '0; mode_i = 2'b10;
    cyc(3);
    // R1: reset state
    for (int i = 0; i < 8; i++) chk(hold_of(i) == 0, "R1 hold reset", hold_of(i), 0);
    chk(upd_done_o == 0, "R1 done reset", int'(upd_done_o), 0);
    rst_n = 1'b1;
    cyc(2);

    // R2 R7: per-bit counting, software update
    for (int i = 0; i < 8; i++) repeat (i + 1) strobe(8'(1 << i));
    sw_pulse();
    chk(upd_done_o == 1, "R9 done after sw", int'(upd_done_o), 1);
    cyc(1);
    for (int i = 0; i < 8; i++) chk(hold_of(i) == i + 1, "R2 R7 count", hold_of(i), i + 1);

    // R5: event in the update cycle belongs to the new interval
    strobe(8'h01); strobe(8'h01);
    evt_i = 8'h01; sw_upd_i = 1; cyc(1); evt_i = 0; sw_upd_i = 0;
    chk(int'(h_bpv) == 2, "R5 boundary old", int'(h_bpv), 2);
    cyc(1); sw_pulse(); cyc(1);
    chk(int'(h_bpv) == 1, "R5 boundary new", int'(h_bpv), 1);

    // R4: unselected sources ignored
    mode_i = 2'b00; pulses = 0;
    strobe(8'h02); sw_pulse(); tick_en_i = 1; cyc(12); tick_en_i = 0;
    ext_upd_i = 1; cyc(4); ext_upd_i = 0; cyc(5);
    chk(pulses == 0, "R4 off mode", pulses, 0);
    chk(int'(h_cv) == 0, "R4 off hold", int'(h_cv), 0);
    mode_i = 2'b11; sw_pulse(); cyc(3);
    chk(pulses == 0, "R4 ext ignores sw", pulses, 0);
    mode_i = 2'b10; ext_upd_i = 1; cyc(4); ext_upd_i = 0; cyc(5);
    chk(pulses == 0, "R4 sw ignores ext", pulses, 0);

    // R8: long external level gives a single update
    mode_i = 2'b11; strobe(8'h80); pulses = 0;
    ext_upd_i = 1; cyc(10); ext_upd_i = 0; cyc(6);
    chk(pulses == 1, "R8 single update", pulses, 1);
    chk(int'(h_cv) == 1, "R8 hold cv", int'(h_cv), 1);
    chk(int'(h_febe) == 1, "R8 hold febe", int'(h_febe), 1);

    // R6: timebase period
    mode_i = 2'b01; cyc(2); pulses = 0;
    tick_en_i = 1; cyc(50); tick_en_i = 0; cyc(1);
    chk(pulses == 10, "R6 steady ticks", pulses, 10);
    pulses = 0;
    for (int k = 0; k < 50; k++) begin tick_en_i = 1; cyc(1); tick_en_i = 0; cyc(1); end
    cyc(1);
    chk(pulses == 10, "R6 sparse ticks", pulses, 10);

    // R3: saturation
    mode_i = 2'b00; evt_i = 8'hFF; cyc(65540); evt_i = 8'h00;
    mode_i = 2'b10; sw_pulse(); cyc(1);
    for (int i = 0; i < 8; i++) begin
      int mx;
      mx = (i == 2) ? 255 : 65535;
      chk(hold_of(i) == mx, "R3 saturate", hold_of(i), mx);
    end
    sw_pulse(); cyc(1);
    chk(int'(h_par) == 0, "R5 cleared after saturate", int'(h_par), 0);

    cyc(2);
    done_flag = 1'b1;
    finish_run();
  end
endmodule